// File: doc/BRIEF.md
# Multi-Stage Capture Trigger Sequencer

This block decides when a capture should be taken. It receives single-cycle event strobes from protocol decoders, such as an address match, a NACK, a command byte or a frame identifier hit. It also receives a small set of digital qualifier pins. From these it produces one trigger pulse per acquisition. Software picks two event inputs: A, which is the primary, stage-one, command or watched event, and B, which is the secondary, stage-two or response event. It also picks one of four sequencing modes. After an arm pulse the sequencer waits for its condition, pulses the trigger once, and then stays in a finished state until it is armed again.

There are four modes. The first fires on the Nth qualified A event. The second is a two-step A-then-B sequence. The third fires when a response fails to arrive within a window after a command. The fourth fires when a watched event stays silent for longer than a limit. An optional pin qualifier masks every event while the selected pin is not at its programmed level. When the trigger fires, the block also starts a post-trigger sample countdown for an external capture buffer. The countdown length comes from the buffer depth and a pre-trigger percentage latched at arm time.

Top module: `trig_seq`

## Requirements
- R1: After reset, armed_o, done_o and trig_o are 0 and post_left_o is 0.
- R2: A cycle with arm_i high discards any progress, including the finished state and partial counts, and makes armed_o 1 and done_o 0 from the next cycle. Events presented in the same cycle as arm_i are ignored.
- R3: When qual_en_i is 1, an event on evt_i is counted only in cycles where pins_i[qual_sel_i] equals qual_lvl_i. When qual_en_i is 0, every event counts.
- R4: With mode_i = 0, the trigger fires on the count_n_i-th qualified event on bit sel_a_i. A count_n_i of 0 or 1 fires on the first such event.
- R5: With mode_i = 1, a qualified event on bit sel_b_i counts only after a qualified event on bit sel_a_i has been seen in an earlier cycle. A B event in the same cycle as that A event does not fire. The first B event after that fires.
- R6: With mode_i = 2, a qualified A event is a command. If no qualified B event arrives during the next timeout_i cycles, the trigger fires. A B event in the last cycle of that window is on time and returns the block to waiting for a command. A timeout_i of 0 disables firing.
- R7: With mode_i = 3, the trigger fires once timeout_i consecutive cycles have passed without a qualified A event, counted from arming or from the last A event. An A event in the final cycle restarts the count. A timeout_i of 0 disables firing.
- R8: trig_o is high for exactly one cycle, which is the cycle after the clock edge that sampled the deciding input. From that cycle onward, done_o is 1, armed_o is 0 and no further trigger occurs until the next arm.
- R9: In the trigger cycle, post_left_o equals floor(DEPTH*(100-p)/100), where p is pre_pct_i captured at arm time and clamped to 100. It then falls by one each cycle until it reaches 0, and post_run_o is 1 exactly while it is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Clear and arm pulse |
| mode_i | input | 2 | 0 Nth event, 1 A then B, 2 response timeout, 3 idle timeout |
| evt_i | input | NEV | Event strobes from decoders |
| sel_a_i | input | $clog2(NEV) | Bit index of event A |
| sel_b_i | input | $clog2(NEV) | Bit index of event B |
| pins_i | input | NQ | Digital qualifier pins |
| qual_en_i | input | 1 | Enable pin qualification |
| qual_sel_i | input | $clog2(NQ) | Qualifier pin index |
| qual_lvl_i | input | 1 | Level the qualifier pin must hold |
| count_n_i | input | 32 | Occurrence count for mode 0 |
| timeout_i | input | 32 | Window or idle limit in cycles, 0 disables |
| pre_pct_i | input | 7 | Pre-trigger share of the buffer in percent |
| armed_o | output | 1 | Waiting for the trigger condition |
| done_o | output | 1 | Trigger has fired since the last arm |
| trig_o | output | 1 | One-cycle trigger pulse |
| post_left_o | output | $clog2(DEPTH+1) | Post-trigger samples still to take |
| post_run_o | output | 1 | Post-trigger countdown in progress |

## Verification
Two pairs of functions can land on the same clock edge. In response-timeout mode, the response strobe can arrive in the very cycle the window expires. The bench counts forward from the command cycle and places B exactly on the last window cycle. A trigger seen there is a failure, and the bench then confirms that a following command with no reply fires exactly one window later. The arm pulse can also coincide with an event. The bench drives both together in first-event mode and expects no trigger until a later, separate event. A similar edge case in idle mode is covered by a watched event in the final allowed cycle, which must push the trigger out by a full interval.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int CNT_W = 32;

    typedef enum logic [1:0] {
        MODE_NTH  = 2'd0,
        MODE_SEQ  = 2'd1,
        MODE_RESP = 2'd2,
        MODE_IDLE = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_STAGE2 = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic ev_a;
        logic ev_b;
    } qual_evt_t;

    // samples after the trigger: depth * (100 - pre) / 100, pre clamped to 100
    function automatic logic [31:0] post_len(input logic [31:0] depth,
                                             input logic [6:0]  pre);
        logic [6:0]  p;
        logic [63:0] prod;
        logic [63:0] quo;
        p    = (pre > 7'd100) ? 7'd100 : pre;
        prod = {32'd0, depth} * {57'd0, 7'd100 - p};
        quo  = prod / 64'd100;
        return quo[31:0];
    endfunction

endpackage

// File: rtl/trig_qual.sv
module trig_qual
    import trig_seq_pkg::*;
#(
    parameter int NEV = 8,
    parameter int NQ  = 4,
    localparam int EW = (NEV > 1) ? $clog2(NEV) : 1,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic [NEV-1:0] evt_i,
    input  logic [EW-1:0]  sel_a_i,
    input  logic [EW-1:0]  sel_b_i,
    input  logic [NQ-1:0]  pins_i,
    input  logic           qual_en_i,
    input  logic [QW-1:0]  qual_sel_i,
    input  logic           qual_lvl_i,
    output qual_evt_t      q_o
);
    logic gate_ok;

    assign gate_ok = !qual_en_i || (pins_i[qual_sel_i] == qual_lvl_i);

    always_comb begin
        q_o.ev_a = evt_i[sel_a_i] && gate_ok;
        q_o.ev_b = evt_i[sel_b_i] && gate_ok;
    end
endmodule

// File: rtl/trig_core.sv
module trig_core
    import trig_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [1:0]       mode_i,
    input  qual_evt_t        q_i,
    input  logic [CNT_W-1:0] count_n_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             fire_o,
    output logic             trig_o,
    output logic             armed_o,
    output logic             done_o
);
    seq_state_e       st, st_nx;
    trig_mode_e       md;
    logic [CNT_W-1:0] cnt, cnt_nx, cnt_inc, n_eff;
    logic [CNT_W-1:0] tmr, tmr_nx, tmr_inc;
    logic             fire;
    logic             to_on;

    assign md      = trig_mode_e'(mode_i);
    assign cnt_inc = cnt + 32'd1;
    assign tmr_inc = tmr + 32'd1;
    assign n_eff   = (count_n_i == '0) ? 32'd1 : count_n_i;
    assign to_on   = (timeout_i != '0);

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        tmr_nx = tmr;
        fire   = 1'b0;
        if (arm_i) begin
            st_nx  = ST_STAGE1;
            cnt_nx = '0;
            tmr_nx = '0;
        end else begin
            case (st)
                ST_STAGE1: begin
                    case (md)
                        MODE_NTH: begin
                            if (q_i.ev_a) begin
                                if (cnt_inc >= n_eff) fire = 1'b1;
                                else                  cnt_nx = cnt_inc;
                            end
                        end
                        MODE_SEQ: begin
                            if (q_i.ev_a) st_nx = ST_STAGE2;
                        end
                        MODE_RESP: begin
                            if (q_i.ev_a && to_on) begin
                                st_nx  = ST_STAGE2;
                                tmr_nx = '0;
                            end
                        end
                        default: begin
                            if (to_on) begin
                                if (q_i.ev_a)                  tmr_nx = '0;
                                else if (tmr_inc >= timeout_i) fire = 1'b1;
                                else                           tmr_nx = tmr_inc;
                            end
                        end
                    endcase
                end
                ST_STAGE2: begin
                    case (md)
                        MODE_SEQ: begin
                            if (q_i.ev_b) fire = 1'b1;
                        end
                        MODE_RESP: begin
                            // a reply in the expiry cycle still wins
                            if (q_i.ev_b)                                st_nx = ST_STAGE1;
                            else if (!to_on)                             st_nx = ST_STAGE1;
                            else if (tmr_inc >= timeout_i)               fire = 1'b1;
                            else                                         tmr_nx = tmr_inc;
                        end
                        default: st_nx = ST_STAGE1;
                    endcase
                end
                default: ;
            endcase
        end
        if (fire) st_nx = ST_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_OFF;
            cnt    <= '0;
            tmr    <= '0;
            trig_o <= 1'b0;
        end else begin
            st     <= st_nx;
            cnt    <= cnt_nx;
            tmr    <= tmr_nx;
            trig_o <= fire;
        end
    end

    assign fire_o  = fire;
    assign armed_o = (st == ST_STAGE1) || (st == ST_STAGE2);
    assign done_o  = (st == ST_DONE);
endmodule

// File: rtl/trig_post.sv
module trig_post
    import trig_seq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic [6:0]    pre_pct_i,
    input  logic          fire_i,
    output logic [PW-1:0] left_o
);
    logic [PW-1:0] plen;

    always_ff @(posedge clk) begin
        if (rst) begin
            plen   <= '0;
            left_o <= '0;
        end else if (arm_i) begin
            plen   <= PW'(post_len(32'(DEPTH), pre_pct_i));
            left_o <= '0;
        end else if (fire_i) begin
            left_o <= plen;
        end else if (left_o != '0) begin
            left_o <= left_o - PW'(1);
        end
    end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int NEV   = 8,
    parameter int NQ    = 4,
    parameter int DEPTH = 1024,
    localparam int EW   = (NEV > 1) ? $clog2(NEV) : 1,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           arm_i,
    input  logic [1:0]     mode_i,
    input  logic [NEV-1:0] evt_i,
    input  logic [EW-1:0]  sel_a_i,
    input  logic [EW-1:0]  sel_b_i,
    input  logic [NQ-1:0]  pins_i,
    input  logic           qual_en_i,
    input  logic [QW-1:0]  qual_sel_i,
    input  logic           qual_lvl_i,
    input  logic [31:0]    count_n_i,
    input  logic [31:0]    timeout_i,
    input  logic [6:0]     pre_pct_i,
    output logic           armed_o,
    output logic           done_o,
    output logic           trig_o,
    output logic [PW-1:0]  post_left_o,
    output logic           post_run_o
);
    qual_evt_t q;
    logic      fire;

    trig_qual #(.NEV(NEV), .NQ(NQ)) u_qual (
        .evt_i      (evt_i),
        .sel_a_i    (sel_a_i),
        .sel_b_i    (sel_b_i),
        .pins_i     (pins_i),
        .qual_en_i  (qual_en_i),
        .qual_sel_i (qual_sel_i),
        .qual_lvl_i (qual_lvl_i),
        .q_o        (q)
    );

    trig_core u_core (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm_i),
        .mode_i    (mode_i),
        .q_i       (q),
        .count_n_i (count_n_i),
        .timeout_i (timeout_i),
        .fire_o    (fire),
        .trig_o    (trig_o),
        .armed_o   (armed_o),
        .done_o    (done_o)
    );

    trig_post #(.DEPTH(DEPTH)) u_post (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm_i),
        .pre_pct_i (pre_pct_i),
        .fire_i    (fire),
        .left_o    (post_left_o)
    );

    assign post_run_o = (post_left_o != '0);
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int PW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          arm_i,
    input logic          trig_o,
    input logic          done_o,
    input logic          armed_o,
    input logic [PW-1:0] post_left_o
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);

    a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done_o && !arm_i) |=> (done_o && !trig_o));

    a_r8_trig_marks_done: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (done_o && !armed_o));

    a_r2_arm_enters: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> (armed_o && !done_o && !trig_o));

    a_r9_countdown: assert property (@(posedge clk) disable iff (rst)
        (post_left_o != '0 && !arm_i) |=> (trig_o || post_left_o == $past(post_left_o) - PW'(1)));
endmodule

bind trig_seq trig_seq_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .arm_i       (arm_i),
    .trig_o      (trig_o),
    .done_o      (done_o),
    .armed_o     (armed_o),
    .post_left_o (post_left_o)
);

// File: tb/sim_trig_seq.sv
module sim_trig_seq;
    localparam int NEV = 8;
    localparam int NQ = 4;
    localparam int DEPTH = 1024;
    localparam int PW = $clog2(DEPTH + 1);
    localparam logic [NEV-1:0] EA = 8'b0000_0010;   // sel_a = 1
    localparam logic [NEV-1:0] EB = 8'b0001_0000;   // sel_b = 4

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [NEV-1:0] evt = '0;
    logic [NQ-1:0] pins = '0;
    logic qen = 1'b0;
    logic [1:0] qsel = 2'd0;
    logic qlvl = 1'b0;
    logic [31:0] cnt_n = 32'd0;
    logic [31:0] tmo = 32'd0;
    logic [6:0] pre = 7'd0;
    logic armed, done, trig, prun;
    logic [PW-1:0] pleft;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int q_cyc[$];
    int q_post[$];
    string q_req[$];

    always #10ns clk = ~clk;

    trig_seq #(.NEV(NEV), .NQ(NQ), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .arm_i(arm), .mode_i(mode), .evt_i(evt),
        .sel_a_i(3'd1), .sel_b_i(3'd4), .pins_i(pins), .qual_en_i(qen),
        .qual_sel_i(qsel), .qual_lvl_i(qlvl), .count_n_i(cnt_n),
        .timeout_i(tmo), .pre_pct_i(pre), .armed_o(armed), .done_o(done),
        .trig_o(trig), .post_left_o(pleft), .post_run_o(prun)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // monitor: pop expected trigger cycle and post count
    always @(negedge clk) begin
        int ec, ep;
        string er;
        if (!rst && trig) begin
            if (q_cyc.size() == 0) begin
                check("R8 unexpected trigger", 1'b0, 1, 0);
            end else begin
                ec = q_cyc.pop_front();
                ep = q_post.pop_front();
                er = q_req.pop_front();
                check({er, " trigger cycle"}, cyc == ec, cyc, ec);
                check("R9 post count at trigger", int'(pleft) == ep, int'(pleft), ep);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            check("watchdog", 1'b0, cyc, 150000);
            summary();
        end
    end

    task automatic expect_at(input int c, input int p, input string req);
        q_cyc.push_back(c);
        q_post.push_back(p);
        q_req.push_back(req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string req);
        idle(2);
        check({req, " pending triggers"}, q_cyc.size() == 0, q_cyc.size(), 0);
        q_cyc.delete();
        q_post.delete();
        q_req.delete();
    endtask

    task automatic do_arm(output int k);
        @(negedge clk);
        arm = 1'b1;
        k = cyc;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic pulse(input logic [NEV-1:0] v, output int k);
        @(negedge clk);
        evt = v;
        k = cyc;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic pulse_exp(input logic [NEV-1:0] v, input int p, input string req);
        @(negedge clk);
        evt = v;
        expect_at(cyc + 1, p, req);
        @(negedge clk);
        evt = '0;
    endtask

    task automatic drive_at(input logic [NEV-1:0] v, input int target);
        while (cyc < target) @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = '0;
    endtask

    function automatic int plen(input int p);
        int pc;
        pc = (p > 100) ? 100 : p;
        return (DEPTH * (100 - pc)) / 100;
    endfunction

    initial begin
        int k, k2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 armed", armed == 1'b0, armed, 0);
        check("R1 done", done == 1'b0, done, 0);
        check("R1 trig", trig == 1'b0, trig, 0);
        check("R1 post_left", pleft == '0, int'(pleft), 0);

        // R4 Nth event, N=3
        mode = 2'd0; cnt_n = 32'd3; pre = 7'd25;
        do_arm(k);
        check("R2 armed after arm", armed == 1'b1, armed, 1);
        check("R2 done cleared", done == 1'b0, done, 0);
        pulse(EA, k);
        pulse(EB, k);
        pulse(EA, k);
        pulse_exp(EA, plen(25), "R4");
        check("R8 done after trigger", done == 1'b1, done, 1);
        check("R8 armed low after trigger", armed == 1'b0, armed, 0);
        idle(3);
        check("R9 countdown", int'(pleft) == plen(25) - 3, int'(pleft), plen(25) - 3);
        check("R9 post_run", prun == 1'b1, prun, 1);
        pulse(EA, k); pulse(EA, k); pulse(EA, k);
        drained("R8 ignored while done");
        check("R8 done holds", done == 1'b1, done, 1);

        // R3 qualifier
        cnt_n = 32'd2; pre = 7'd0; qen = 1'b1; qsel = 2'd2; qlvl = 1'b1; pins = 4'b1011;
        do_arm(k);
        pulse(EA, k); pulse(EA, k);
        drained("R3 masked events");
        check("R3 still armed", armed == 1'b1, armed, 1);
        pins = 4'b0100;
        pulse(EA, k);
        pulse_exp(EA, plen(0), "R3");
        drained("R3");
        qen = 1'b0;

        // R4 N=0 and N=1 fire on the first event
        cnt_n = 32'd0; pre = 7'd100;
        do_arm(k);
        pulse_exp(EA, 0, "R4 n0");
        drained("R4 n0");
        cnt_n = 32'd1; pre = 7'd33;
        do_arm(k);
        pulse_exp(EA, plen(33), "R4 n1");
        drained("R4 n1");

        // R5 sequence
        mode = 2'd1; pre = 7'd120;
        do_arm(k);
        pulse(EB, k);
        pulse(EA | EB, k);
        drained("R5 B before or with A");
        check("R5 still armed", armed == 1'b1, armed, 1);
        pulse_exp(EB, plen(120), "R5");
        drained("R5");

        // R6 response timeout, T=5
        mode = 2'd2; tmo = 32'd5; pre = 7'd50;
        do_arm(k);
        pulse(EA, k);
        drive_at(EB, k + 5);            // reply in the expiry cycle
        idle(10);
        drained("R6 reply at expiry");
        check("R6 armed after on-time reply", armed == 1'b1, armed, 1);
        pulse(EA, k);
        drive_at(EB, k + 2);
        idle(10);
        drained("R6 early reply");
        @(negedge clk);
        evt = EA;
        k2 = cyc;
        expect_at(k2 + 6, plen(50), "R6 missing reply");
        @(negedge clk);
        evt = '0;
        idle(10);
        drained("R6 missing reply");
        tmo = 32'd0;
        do_arm(k);
        pulse(EA, k);
        idle(20);
        drained("R6 zero timeout");
        check("R6 zero timeout armed", armed == 1'b1, armed, 1);

        // R7 idle timeout, T=6
        mode = 2'd3; tmo = 32'd6; pre = 7'd10;
        do_arm(k);
        expect_at(k + 7, plen(10), "R7 from arm");
        idle(12);
        drained("R7 from arm");
        do_arm(k);
        drive_at(EA, k + 3);
        drive_at(EA, k + 9);            // last allowed cycle
        expect_at(k + 16, plen(10), "R7 restart");
        idle(12);
        drained("R7 restart");
        tmo = 32'd0;
        do_arm(k);
        idle(20);
        drained("R7 zero timeout");
        check("R7 zero timeout armed", armed == 1'b1, armed, 1);

        // R2 re-arm clears partial count
        mode = 2'd0; cnt_n = 32'd2; pre = 7'd25;
        do_arm(k);
        pulse(EA, k);
        do_arm(k);
        pulse(EA, k);
        drained("R2 rearm clears count");
        pulse_exp(EA, plen(25), "R2 rearm");
        drained("R2 rearm");

        // R2 arm and event in the same cycle
        cnt_n = 32'd1;
        @(negedge clk);
        arm = 1'b1;
        evt = EA;
        @(negedge clk);
        arm = 1'b0;
        evt = '0;
        drained("R2 event with arm ignored");
        check("R2 armed", armed == 1'b1, armed, 1);
        pulse_exp(EA, plen(25), "R2 after arm");
        drained("R2 after arm");

        summary();
    end
endmodule